// File: doc/BRIEF.md
# Page Write Buffer Sequencer

This block sits between a two-wire serial slave front end and a byte-wide memory array. While a write transaction is open, the front end hands it a start address and then one strobe per received data byte. The block keeps those bytes in a small page buffer and records which columns of the page have been filled. The column pointer moves only within the page. When more bytes arrive than the page holds, the pointer wraps to column 0 and the newer bytes replace the older ones.

When the front end reports the end of the transaction, the block opens a single timed write interval and raises `busy`. Early in that interval it drains every filled column to the memory write port, in ascending column order. It then holds `busy` until the programmed cycle count has run out. The front end uses `busy` to refuse new selects until the interval is over. If a transaction is abandoned, for example by a restart on the bus or a protect rejection, the buffer is discarded and no write interval starts.

Top module: `pwb_seq`

## Requirements
- R1: A pulse on `addr_load` latches the page from `addr_in[ADDR_W-1:CW]` and the column from `addr_in[CW-1:0]`, where CW = log2(PAGE_BYTES). Each accepted `byte_stb` stores `byte_in` at the current column and then advances the column by one.
- R2: The column advances modulo PAGE_BYTES. After column PAGE_BYTES-1 it returns to column 0, and a later byte for a column replaces the earlier one.
- R3: Every `mem_addr` issued during a write interval carries the latched page in its upper bits. The latched page does not change while `busy` is high.
- R4: `stop_commit` with at least one filled column raises `busy` on the next clock. The memory port then issues exactly one `mem_we` pulse per filled column, in strictly ascending column order, and only while `busy` is high.
- R5: `busy` stays high for exactly WR_CYCLES clock cycles and then falls by itself.
- R6: While `busy` is high, `addr_load`, `byte_stb` and `stop_commit` have no effect on the buffer, the port or the interval length.
- R7: `abort` while idle discards every filled column. A later `stop_commit` without new bytes starts no interval.
- R8: `stop_commit` with no filled column (including right after `addr_load`) leaves `busy` low.
- R9: The fill record clears at the end of each write interval. Memory locations whose columns were not filled in a transaction are never written.
- R10: After reset, `busy` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Start a transaction at `addr_in` |
| addr_in | input | ADDR_W | Start address: page bits over column bits |
| byte_stb | input | 1 | One received data byte is valid |
| byte_in | input | 8 | Received data byte |
| stop_commit | input | 1 | Transaction ended; commit the buffer |
| abort | input | 1 | Discard the buffer |
| busy | output | 1 | Write interval in progress |
| mem_we | output | 1 | Memory array write enable |
| mem_addr | output | ADDR_W | Memory array write address |
| mem_wdata | output | 8 | Memory array write data |

## Verification
The bench sweeps every page of a small 64-byte configuration and several start columns. For each one it sends transactions of 1, 2, 7, 16, 17, 20 and 33 bytes. Short runs show that unfilled columns stay untouched. A run of exactly 16 bytes fills the page with no overlap. Runs past 16 separate a column pointer that wraps from one that carries into the page, and show that the newest byte wins. Separate sequences commit an empty buffer, abort a filled buffer, and press every input during a busy interval, so that each ignored stimulus can be seen not to move the port or `busy`.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [0:0] {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/pwb_colptr.sv
module pwb_colptr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_col,
  input  logic          adv,
  output logic [CW-1:0] col
);
  logic [CW-1:0] col_d, col_q;

  always_comb begin
    col_d = col_q;
    if (load)     col_d = load_col;
    else if (adv) col_d = col_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= col_d;
  end

  assign col = col_q;

  // R2: column wraps inside the page
  assert_col_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && col_q == {CW{1'b1}}) |=> (col_q == '0));
endmodule

// File: rtl/pwb_buffer.sv
module pwb_buffer #(
  parameter int DEPTH = 16,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_col,
  input  logic [7:0]    wr_data,
  input  logic          clr,
  input  logic [CW-1:0] rd_col,
  output logic [7:0]    rd_data,
  output logic          rd_vld,
  output logic          any_vld
);
  logic [DEPTH-1:0] mask_d, mask_q;
  logic [7:0]       data_q [DEPTH];

  always_comb begin
    mask_d = mask_q;
    if (clr) mask_d = '0;
    else if (wr_en) begin
      for (int i = 0; i < DEPTH; i++)
        if (wr_col == CW'(i)) mask_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en && wr_col == CW'(g)) data_q[g] <= wr_data;
    end
  end

  assign rd_data = data_q[rd_col];
  assign rd_vld  = mask_q[rd_col];
  assign any_vld = |mask_q;

  // R7: a clear leaves no filled column
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask_q == '0));
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer
  import pwb_pkg::*;
#(
  parameter int CYCLES = 500000,
  parameter int EW     = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [EW-1:0] elapsed
);
  localparam logic [EW-1:0] LAST = EW'(CYCLES - 1);

  tmr_state_e    st_d, st_q;
  logic [EW-1:0] el_d, el_q;

  always_comb begin
    st_d = st_q;
    el_d = el_q;
    case (st_q)
      TMR_IDLE: if (start) begin
        st_d = TMR_RUN;
        el_d = '0;
      end
      TMR_RUN: begin
        if (el_q == LAST) st_d = TMR_IDLE;
        else              el_d = el_q + EW'(1);
      end
      default: st_d = TMR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TMR_IDLE;
      el_q <= '0;
    end else begin
      st_q <= st_d;
      el_q <= el_d;
    end
  end

  assign busy    = (st_q == TMR_RUN);
  assign elapsed = el_q;

  // R5: interval ends one clock after the count runs out
  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && el_q == LAST) |=> !busy);
  // R5: every interval begins at count zero
  assert_busy_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (el_q == '0));
endmodule

// File: rtl/pwb_seq.sv
module pwb_seq #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [7:0]        byte_in,
  input  logic              stop_commit,
  input  logic              abort,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int CW = $clog2(PAGE_BYTES);
  localparam int PW = ADDR_W - CW;
  localparam int EW = $clog2(WR_CYCLES + 1);
  localparam logic [EW-1:0] LAST = EW'(WR_CYCLES - 1);
  localparam logic [EW-1:0] SCAN_END = EW'(PAGE_BYTES);

  logic          idle, ld, wr, clr, start, last;
  logic [CW-1:0] col, rd_col;
  logic [7:0]    rd_data;
  logic          rd_vld, any_vld, scan_act;
  logic [EW-1:0] elapsed;
  logic [PW-1:0] page_d, page_q;
  logic              we_d;
  logic [ADDR_W-1:0] addr_d;

  assign idle  = !busy;
  assign ld    = idle && addr_load && !abort;
  assign wr    = idle && byte_stb && !abort && !addr_load && !stop_commit;
  assign start = idle && stop_commit && any_vld && !abort && !addr_load;
  assign last  = busy && (elapsed == LAST);
  assign clr   = (idle && (abort || addr_load)) || last;

  pwb_colptr #(.CW(CW)) u_col (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_col(addr_in[CW-1:0]),
    .adv(wr), .col(col)
  );

  pwb_buffer #(.DEPTH(PAGE_BYTES), .CW(CW)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .wr_col(col), .wr_data(byte_in),
    .clr(clr), .rd_col(rd_col), .rd_data(rd_data), .rd_vld(rd_vld),
    .any_vld(any_vld)
  );

  pwb_timer #(.CYCLES(WR_CYCLES), .EW(EW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .elapsed(elapsed)
  );

  // page register
  always_comb begin
    page_d = page_q;
    if (ld) page_d = addr_in[ADDR_W-1:CW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  // drain scan over the first PAGE_BYTES cycles of the interval
  assign scan_act = busy && (elapsed < SCAN_END);
  assign rd_col   = elapsed[CW-1:0];
  assign we_d     = scan_act && rd_vld;
  assign addr_d   = {page_q, rd_col};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= we_d;
      if (we_d) begin
        mem_addr  <= addr_d;
        mem_wdata <= rd_data;
      end
    end
  end

  // R4: the array is written only inside a write interval
  assert_we_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R3: page held for the whole interval
  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(page_q));
  // R8: no interval without a filled column
  assert_no_empty_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(any_vld));
  // R10: quiet port coming out of reset
  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !mem_we);
endmodule

// File: tb/sim_pwb_seq.sv
module sim_pwb_seq;
  localparam int AW = 6;
  localparam int PB = 16;
  localparam int WC = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          addr_load, byte_stb, stop_commit, abort;
  logic [AW-1:0] addr_in;
  logic [7:0]    byte_in;
  logic          busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_mem [1<<AW];
  logic [7:0] act_mem [1<<AW];
  int wcount, last_col, cur_page, blen, last_len, cycles;

  always #4 clk = ~clk;

  pwb_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in), .stop_commit(stop_commit),
    .abort(abort), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  task automatic chk(input bit ok, input string req, input int a, input int e);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  function automatic logic [7:0] dgen(int pg, int col, int n, int i);
    return 8'((pg * 37 + i * 11 + col * 3 + n * 5) ^ 8'hA5);
  endfunction

  // port monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        act_mem[mem_addr] = mem_wdata;
        wcount++;
        if (int'(mem_addr[AW-1:4]) != cur_page)
          chk(0, "R3 page of write", int'(mem_addr[AW-1:4]), cur_page);
        if (int'(mem_addr[3:0]) <= last_col)
          chk(0, "R4 ascending column", int'(mem_addr[3:0]), last_col + 1);
        last_col = int'(mem_addr[3:0]);
      end
      if (busy) blen++;
      else if (blen != 0) begin
        last_len = blen;
        blen = 0;
      end
    end
  end

  task automatic compare_mem(input string req);
    int mism = 0;
    for (int a = 0; a < (1 << AW); a++)
      if (act_mem[a] !== exp_mem[a]) mism++;
    chk(mism == 0, req, mism, 0);
  endtask

  task automatic no_busy_window(input string req);
    int seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic fill(input int pg, input int col, input int n, input bit model);
    @(negedge clk);
    addr_load = 1'b1;
    addr_in   = AW'(pg * PB + col);
    @(negedge clk);
    addr_load = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_stb = 1'b1;
      byte_in  = dgen(pg, col, n, i);
      if (model) exp_mem[pg * PB + ((col + i) % PB)] = dgen(pg, col, n, i);
      @(negedge clk);
    end
    byte_stb = 1'b0;
  endtask

  task automatic commit_and_wait(input int pg, input int nbytes);
    int want;
    want = (nbytes >= PB) ? PB : nbytes;
    wcount   = 0;
    last_col = -1;
    cur_page = pg;
    last_len = 0;
    stop_commit = 1'b1;
    @(negedge clk);
    stop_commit = 1'b0;
    chk(busy == 1'b1, "R4 busy rises after commit", int'(busy), 1);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(last_len == WC, "R5 busy length", last_len, WC);
    chk(wcount == want, "R4 write count", wcount, want);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(0, "watchdog", cycles, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int lens [7] = '{1, 2, 7, 16, 17, 20, 33};
    int cols [3] = '{0, 5, 15};
    rst_n = 1'b0;
    addr_load = 1'b0; byte_stb = 1'b0; stop_commit = 1'b0; abort = 1'b0;
    addr_in = '0; byte_in = '0;
    blen = 0; last_len = 0; wcount = 0; last_col = -1; cur_page = 0;
    for (int a = 0; a < (1 << AW); a++) begin
      exp_mem[a] = 8'hFF;
      act_mem[a] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
    chk(mem_we == 1'b0, "R10 mem_we after reset", int'(mem_we), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: empty commit right after a load
    @(negedge clk);
    addr_load = 1'b1; addr_in = AW'(21);
    @(negedge clk);
    addr_load = 1'b0; stop_commit = 1'b1;
    @(negedge clk);
    stop_commit = 1'b0;
    no_busy_window("R8 empty commit");

    // R1 R2 R4 R9 sweep over pages, start columns and lengths
    for (int pg = 0; pg < 4; pg++)
      for (int c = 0; c < 3; c++)
        for (int l = 0; l < 7; l++) begin
          fill(pg, cols[c], lens[l], 1'b1);
          commit_and_wait(pg, lens[l]);
          compare_mem("R1 R2 R9 array contents");
        end

    // R9: repeated commit with no new bytes
    stop_commit = 1'b1;
    @(negedge clk);
    stop_commit = 1'b0;
    no_busy_window("R9 fill record cleared");

    // R7: abort discards
    fill(2, 3, 5, 1'b0);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    stop_commit = 1'b1;
    @(negedge clk);
    stop_commit = 1'b0;
    no_busy_window("R7 abort then commit");
    compare_mem("R7 array untouched");

    // R6: inputs ignored during busy
    fill(1, 9, 4, 1'b1);
    wcount = 0; last_col = -1; cur_page = 1; last_len = 0;
    stop_commit = 1'b1;
    @(negedge clk);
    stop_commit = 1'b0;
    @(negedge clk);
    addr_load = 1'b1; addr_in = AW'(3 * PB + 2);
    @(negedge clk);
    addr_load = 1'b0;
    for (int i = 0; i < 3; i++) begin
      byte_stb = 1'b1; byte_in = 8'(8'h5A + i);
      @(negedge clk);
    end
    byte_stb = 1'b0;
    stop_commit = 1'b1;
    @(negedge clk);
    stop_commit = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(last_len == WC, "R6 busy length unchanged", last_len, WC);
    chk(wcount == 4, "R6 write count", wcount, 4);
    compare_mem("R6 array contents");
    stop_commit = 1'b1;
    @(negedge clk);
    stop_commit = 1'b0;
    no_busy_window("R6 no bytes kept from busy");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule